// File: doc/BRIEF.md
# Addressable Bit Register with Decode Mode

The block keeps a small bank of single-bit outputs (eight by default). An address input picks one of them, and a one-bit data input can be placed into that position while the others are left alone. Two active-low controls, a clear and an enable, choose between four behaviours. The first writes one addressed bit. The second freezes the whole bank. The third zeroes the whole bank. The fourth is a decode mode: the addressed bit follows the data input and all other bits are forced low. Used this way, the block works as a one-of-N demultiplexer.

All inputs are sampled on the rising edge of the system clock, and each output comes straight from its own flip-flop. The block can therefore be placed in a synchronous FPGA design as a bank of individually settable control flags or strobes, and it contains no level-sensitive storage. A synchronous active-high reset zeroes the bank independently of the clear control.

Top module: `addr_latch`

## Requirements
- R1: Address value k (0 to 7, bit 2 of `addr` the most significant) selects output `q[k]`: `addr`=0 reaches `q[0]` and `addr`=7 reaches `q[7]`.
- R2: With `clr_n`=1 and `en_n`=0 at a rising edge, the addressed bit takes `din` after that edge and every other bit keeps its value.
- R3: With `clr_n`=1 and `en_n`=1 at a rising edge, all bits keep their values whatever `addr` and `din` are.
- R4: With `clr_n`=0 and `en_n`=1 at a rising edge, all bits become 0 whatever `addr` and `din` are.
- R5: With `clr_n`=0 and `en_n`=0 at a rising edge, the addressed bit takes `din` and every other bit becomes 0, so at most one bit of `q` is 1.
- R6: `rst`=1 at a rising edge makes all bits 0 after that edge, overriding `clr_n`, `en_n`, `addr` and `din`.
- R7: `q` changes only at rising clock edges; input changes between edges have no effect on `q` until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Data bit to place in the addressed position |
| addr | input | 3 | Bit select, bit 2 most significant |
| clr_n | input | 1 | Active-low clear control |
| en_n | input | 1 | Active-low enable control |
| q | output | 8 | Registered output bits |

## Verification
On every clocked cycle the embedded properties check what each control mode does to the bank one edge later. In write mode, only the addressed bit may move and it must equal the sampled data. Hold mode must leave the bank stable, clear mode must leave it zero, and decode mode must produce exactly the shifted data bit. The address decoder is also checked to be one-hot. The address ordering at its two extremes, reset taking priority over every control, and the absence of any change to `q` between edges can only be shown by the bench. Its directed scenarios and a long random run are compared edge by edge with a behavioural model.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Mode code is {clr_n, en_n}
  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,
    MODE_CLEAR  = 2'b01,
    MODE_WRITE  = 2'b10,
    MODE_HOLD   = 2'b11
  } lat_mode_e;

endpackage

// File: rtl/lat_mode_dec.sv
module lat_mode_dec
  import addr_latch_pkg::*;
(
  input  logic      clr_n,
  input  logic      en_n,
  output lat_mode_e mode
);

  always_comb begin
    unique case ({clr_n, en_n})
      2'b00:   mode = MODE_DECODE;
      2'b01:   mode = MODE_CLEAR;
      2'b10:   mode = MODE_WRITE;
      default: mode = MODE_HOLD;
    endcase
  end

endmodule

// File: rtl/lat_addr_dec.sv
module lat_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  sel
);

  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

  always_comb begin
    // R1
    addr_sel_onehot_chk: assert ($onehot(sel) || $isunknown(addr));
  end

endmodule

// File: rtl/lat_bit_cell.sv
module lat_bit_cell
  import addr_latch_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lat_mode_e mode,
  input  logic      hit,
  input  logic      din,
  output logic      q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    unique case (mode)
      MODE_WRITE:  if (hit) q_nxt = din;
      MODE_HOLD:   q_nxt = q;
      MODE_CLEAR:  q_nxt = 1'b0;
      MODE_DECODE: q_nxt = hit & din;
      default:     q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end

endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr_n,
  input  logic              en_n,
  output logic [NBITS-1:0]  q
);

  lat_mode_e        mode;
  logic [NBITS-1:0] sel;

  lat_mode_dec u_mode (
    .clr_n (clr_n),
    .en_n  (en_n),
    .mode  (mode)
  );

  lat_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    lat_bit_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .hit  (sel[i]),
      .din  (din),
      .q    (q[i])
    );
  end

  // R2
  write_keeps_others_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !en_n) |=>
      ((q & ~(NBITS'(1) << $past(addr))) == ($past(q) & ~(NBITS'(1) << $past(addr)))));

  // R2
  write_sets_target_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !en_n) |=> (q[$past(addr)] == $past(din)));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && en_n) |=> $stable(q));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && en_n) |=> (q == '0));

  // R5
  decode_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |=> (q == (NBITS'($past(din)) << $past(addr))));

  // R5
  decode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !en_n) |=> $onehot0(q));

endmodule

// File: tb/sim_addr_latch.sv
module sim_addr_latch;

  logic       clk = 1'b0;
  logic       rst;
  logic       din;
  logic [2:0] addr;
  logic       clr_n;
  logic       en_n;
  logic [7:0] q;

  logic [7:0] model;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_latch u0 (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .addr  (addr),
    .clr_n (clr_n),
    .en_n  (en_n),
    .q     (q)
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected=%b", req, q, exp);
    end
  endtask

  // Behavioural model of one rising edge
  function automatic logic [7:0] next_model(logic [7:0] cur, logic r, logic c,
                                            logic e, logic [2:0] a, logic d);
    logic [7:0] n;
    n = cur;
    if (r) n = 8'h00;
    else if (c && !e) n[a] = d;
    else if (!c && e) n = 8'h00;
    else if (!c && !e) begin
      n = 8'h00;
      n[a] = d;
    end
    return n;
  endfunction

  // Drive at negedge, one posedge, compare at next negedge
  task automatic step(input logic r, input logic c, input logic e,
                      input logic [2:0] a, input logic d, input string req);
    rst = r; clr_n = c; en_n = e; addr = a; din = d;
    @(posedge clk);
    model = next_model(model, r, c, e, a, d);
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    rst = 1; din = 1; addr = 3'd5; clr_n = 1; en_n = 0;
    model = 8'h00;
    @(negedge clk);
    step(1, 1, 0, 3'd5, 1, "R6 reset");
    // R1 address extremes in write mode
    step(0, 1, 0, 3'd0, 1, "R1 addr0");
    check("R1 addr0 exact", 8'h01);
    step(0, 1, 0, 3'd7, 1, "R1 addr7");
    check("R1 addr7 exact", 8'h81);
    // R2 write others kept
    step(0, 1, 0, 3'd3, 1, "R2 set");
    step(0, 1, 0, 3'd0, 0, "R2 clear bit");
    check("R2 exact", 8'h88);
    // R3 hold
    step(0, 1, 1, 3'd1, 1, "R3 hold");
    check("R3 exact", 8'h88);
    // R7 mid-cycle input changes do not reach q
    addr = 3'd2; din = 1; clr_n = 0; en_n = 0;
    #2 check("R7 between edges", 8'h88);
    clr_n = 1; en_n = 1;
    #1 check("R7 between edges 2", 8'h88);
    @(negedge clk);
    // R5 decode
    step(0, 0, 0, 3'd6, 1, "R5 decode");
    check("R5 exact", 8'h40);
    step(0, 0, 0, 3'd2, 0, "R5 decode zero");
    check("R5 exact zero", 8'h00);
    // R4 clear
    step(0, 1, 0, 3'd4, 1, "R2 set");
    step(0, 0, 1, 3'd4, 1, "R4 clear");
    check("R4 exact", 8'h00);
    // R6 reset overrides write
    step(0, 1, 0, 3'd1, 1, "R2 set");
    step(1, 1, 0, 3'd2, 1, "R6 overrides");
    check("R6 exact", 8'h00);
    // Random run
    for (int i = 0; i < 3000; i++) begin
      logic c, e, d, r;
      logic [2:0] a;
      string tag;
      r = ($urandom_range(0, 63) == 0);
      c = 1'($urandom); e = 1'($urandom); d = 1'($urandom); a = 3'($urandom);
      if (r) tag = "R6 random";
      else if (c && !e) tag = "R2 random";
      else if (c && e) tag = "R3 random";
      else if (!c && e) tag = "R4 random";
      else tag = "R5 random";
      step(r, c, e, a, d, tag);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: q=%b expected=completion", q);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule